// File: doc/BRIEF.md
# Remote-Only Module-Side Line Cache

This block is a cache shared by every streaming processor of one GPU module. It sits between the processors' first-level caches and the module's memory-side cache. Each request arrives from the processor side, and the block looks at its physical address to find the owning DRAM partition. Lines are interleaved across partitions at 128-byte granularity.

Requests that belong to the module's own partition are forwarded unchanged to the local port, and their answer is returned as it comes back. Requests that belong to another module are served from a set-associative store where possible, and otherwise go out on the inter-module port. Only read misses allocate. Writes are write-through. Atomics are never cached.

At a synchronization point, processors send invalidate commands that carry an epoch number. The first command of a new epoch clears the whole store. Later copies of the same epoch are dropped. While the clear is running, new requests are held off. The block handles one request at a time.

Top module: `gpm_remote_cache`

## Requirements
- R1: The owning partition is address bits [8:7]. A request whose partition equals PART_ID (default 0) leaves on the local port the cycle after acceptance, with the same op, address and write data. Its response is returned unchanged, and it is never cached, so repeating a local read produces a second local transaction. The local and remote ports are never both active in the same cycle.
- R2: A remote read that misses sends one read on the remote port with the line-aligned address (bits [6:0] cleared). It stores the returned 1024-bit line and answers with the 32-bit word selected by address bits [6:2]. Word i sits at line bits [32*i+31:32*i].
- R3: A remote read that hits answers on the cycle after acceptance, and produces no traffic on either port.
- R4: A remote write (op 1) is always forwarded on the remote port. On a hit, the stored word is updated as well, so a later read of it hits and returns the new value. The write is acknowledged with the low word of the remote response.
- R5: A remote write that misses allocates nothing, so a following read of that line misses.
- R6: An atomic (op 2) is sent on the port that owns its address and is never cached. A remote atomic that hits drops the matching line. The response is the low word of the port's answer. Read is op 0.
- R7: An invalidate whose epoch differs from the last one serviced clears every line. req_ready stays low from the next cycle for at least SETS cycles, and lines fetched before the invalidate miss afterwards.
- R8: An invalidate whose epoch equals the last serviced epoch has no effect: req_ready stays high and cached lines still hit. The epoch after reset is 0.
- R9: Replacement uses one recently-used bit per way. Any access or fill sets its way's bit, and when all bits would be set, only the accessed way's bit remains. The victim is the lowest invalid way, otherwise the lowest way whose bit is clear.
- R10: After reset, req_ready is high and rsp_valid, loc_valid and rmt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor-side request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_op | input | 2 | 0 read, 1 write, 2 atomic add |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write or atomic operand |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data, or acknowledge/atomic result |
| loc_valid | output | 1 | Local-port request pulse |
| loc_op | output | 2 | Local-port op |
| loc_addr | output | 32 | Local-port address |
| loc_wdata | output | 32 | Local-port write data |
| loc_rsp_valid | input | 1 | Local-port answer pulse |
| loc_rsp_rdata | input | 32 | Local-port answer data |
| rmt_valid | output | 1 | Remote-port request pulse |
| rmt_op | output | 2 | Remote-port op |
| rmt_addr | output | 32 | Remote-port address |
| rmt_wdata | output | 32 | Remote-port write data |
| rmt_rsp_valid | input | 1 | Remote-port answer pulse |
| rmt_rsp_line | input | 1024 | Remote answer: full line, or result in low word |
| inv_valid | input | 1 | Invalidate command pulse |
| inv_epoch | input | 4 | Epoch of the synchronization event |

## Verification
The hardest case to reach from the ports is a set with every way valid and a replacement history that is not the plain fill order. Exposing that victim requires four fills into one set, followed by hits on chosen ways, followed by a fifth miss. The choice of victim then shows only through which of the earlier lines miss afterwards, so the bench counts remote-port transactions around each read.

Duplicate invalidates are also awkward to observe. The bench sends copies of an epoch on consecutive cycles, some of them during a running clear. It then refetches a line and checks that a later copy leaves it resident.

// File: rtl/gpm_rc_pkg.sv
package gpm_rc_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_AMO = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_WLOC  = 2'd2,
        ST_WRMT  = 2'd3
    } st_e;
endpackage

// File: rtl/gpm_rc_tags.sv
module gpm_rc_tags #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 22,
    localparam int SB = $clog2(SETS),
    localparam int WB = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SB-1:0]    lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WB-1:0]    hit_way,
    output logic [WB-1:0]    vic_way,
    input  logic             touch_en,
    input  logic [SB-1:0]    touch_set,
    input  logic [WB-1:0]    touch_way,
    input  logic             fill_en,
    input  logic [SB-1:0]    fill_set,
    input  logic [WB-1:0]    fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             kill_en,
    input  logic [SB-1:0]    kill_set,
    input  logic [WB-1:0]    kill_way,
    input  logic             clr_en,
    input  logic [SB-1:0]    clr_set
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  mru_q   [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
                hit     = 1'b1;
                hit_way = WB'(w);
            end
        end
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        vic_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_q[lk_set][w]) begin
                found   = 1'b1;
                vic_way = WB'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !mru_q[lk_set][w]) begin
                found   = 1'b1;
                vic_way = WB'(w);
            end
        end
    end

    logic            upd_en;
    logic [SB-1:0]   upd_set;
    logic [WB-1:0]   upd_way;
    logic [WAYS-1:0] upd_val;

    always_comb begin
        upd_en  = touch_en || fill_en;
        upd_set = fill_en ? fill_set : touch_set;
        upd_way = fill_en ? fill_way : touch_way;
        upd_val = mru_q[upd_set] | (WAYS'(1) << upd_way);
        if (&upd_val) upd_val = WAYS'(1) << upd_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                mru_q[s]   <= '0;
            end
        end else begin
            if (clr_en) begin
                valid_q[clr_set] <= '0;
                mru_q[clr_set]   <= '0;
            end
            if (kill_en) valid_q[kill_set][kill_way] <= 1'b0;
            if (fill_en) valid_q[fill_set][fill_way] <= 1'b1;
            if (upd_en)  mru_q[upd_set] <= upd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
    end

    // R9: the recently-used bits of a set never end up all set
    p_mru_not_full_r9: assert property (@(posedge clk) disable iff (rst)
        !(&mru_q[lk_set]));
endmodule

// File: rtl/gpm_rc_data.sv
module gpm_rc_data #(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int LINE_W = 1024,
    parameter int DATA_W = 32,
    localparam int SB  = $clog2(SETS),
    localparam int WB  = $clog2(WAYS),
    localparam int WIB = $clog2(LINE_W / DATA_W)
) (
    input  logic              clk,
    input  logic [SB-1:0]     rd_set,
    input  logic [WB-1:0]     rd_way,
    output logic [LINE_W-1:0] rd_line,
    input  logic              line_en,
    input  logic [SB-1:0]     line_set,
    input  logic [WB-1:0]     line_way,
    input  logic [LINE_W-1:0] line_data,
    input  logic              word_en,
    input  logic [SB-1:0]     word_set,
    input  logic [WB-1:0]     word_way,
    input  logic [WIB-1:0]    word_idx,
    input  logic [DATA_W-1:0] word_data
);
    logic [LINE_W-1:0] store_q [SETS][WAYS];

    assign rd_line = store_q[rd_set][rd_way];

    always_ff @(posedge clk) begin
        if (line_en) store_q[line_set][line_way] <= line_data;
        if (word_en) store_q[word_set][word_way][word_idx*DATA_W +: DATA_W] <= word_data;
    end
endmodule

// File: rtl/gpm_remote_cache.sv
module gpm_remote_cache
    import gpm_rc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int NPART      = 4,
    parameter int PART_ID    = 0,
    parameter int WAYS       = 4,
    parameter int SETS       = 8,
    parameter int EPOCH_W    = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int PB     = $clog2(NPART),
    localparam int SB     = $clog2(SETS),
    localparam int WB     = $clog2(WAYS),
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WPL    = LINE_W / DATA_W,
    localparam int WIB    = $clog2(WPL),
    localparam int BB     = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - OFF_W - SB
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               loc_valid,
    output logic [1:0]         loc_op,
    output logic [ADDR_W-1:0]  loc_addr,
    output logic [DATA_W-1:0]  loc_wdata,
    input  logic               loc_rsp_valid,
    input  logic [DATA_W-1:0]  loc_rsp_rdata,
    output logic               rmt_valid,
    output logic [1:0]         rmt_op,
    output logic [ADDR_W-1:0]  rmt_addr,
    output logic [DATA_W-1:0]  rmt_wdata,
    input  logic               rmt_rsp_valid,
    input  logic [LINE_W-1:0]  rmt_rsp_line,
    input  logic               inv_valid,
    input  logic [EPOCH_W-1:0] inv_epoch
);
    st_e               st;
    logic              pend;
    logic [EPOCH_W-1:0] last_ep;
    logic [SB-1:0]     fl_idx;
    logic              fill_pend;
    logic [SB-1:0]     f_set;
    logic [WB-1:0]     f_way;
    logic [TAG_W-1:0]  f_tag;
    logic [WIB-1:0]    f_word;

    // address decode: partition, set, tag (upper bits plus partition), word
    logic [PB-1:0]    d_part;
    logic [SB-1:0]    d_set;
    logic [TAG_W-1:0] d_tag;
    logic [WIB-1:0]   d_word;
    logic             d_remote;

    assign d_part   = req_addr[OFF_W +: PB];
    assign d_set    = req_addr[OFF_W + PB +: SB];
    assign d_tag    = {req_addr[ADDR_W-1 : OFF_W + PB + SB], d_part};
    assign d_word   = req_addr[BB +: WIB];
    assign d_remote = (d_part != PB'(PART_ID));

    op_e  op;
    logic hit;
    logic [WB-1:0] hit_way, vic_way;
    logic [LINE_W-1:0] rd_line;
    logic new_inv, acc, rd_hit, wr_hit, amo_kill, fill_now;

    assign op        = op_e'(req_op);
    assign new_inv   = inv_valid && (inv_epoch != last_ep);
    assign req_ready = (st == ST_IDLE) && !pend && !new_inv;
    assign acc       = req_valid && req_ready;
    assign rd_hit    = acc && d_remote && op == OP_RD  && hit;
    assign wr_hit    = acc && d_remote && op == OP_WR  && hit;
    assign amo_kill  = acc && d_remote && op == OP_AMO && hit;
    assign fill_now  = (st == ST_WRMT) && rmt_rsp_valid && fill_pend;

    gpm_rc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .lk_set(d_set), .lk_tag(d_tag),
        .hit(hit), .hit_way(hit_way), .vic_way(vic_way),
        .touch_en(rd_hit || wr_hit), .touch_set(d_set), .touch_way(hit_way),
        .fill_en(fill_now), .fill_set(f_set), .fill_way(f_way), .fill_tag(f_tag),
        .kill_en(amo_kill), .kill_set(d_set), .kill_way(hit_way),
        .clr_en(st == ST_FLUSH), .clr_set(fl_idx)
    );

    gpm_rc_data #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_set(d_set), .rd_way(hit_way), .rd_line(rd_line),
        .line_en(fill_now), .line_set(f_set), .line_way(f_way), .line_data(rmt_rsp_line),
        .word_en(wr_hit), .word_set(d_set), .word_way(hit_way),
        .word_idx(d_word), .word_data(req_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            pend      <= 1'b0;
            last_ep   <= '0;
            fl_idx    <= '0;
            fill_pend <= 1'b0;
            f_set     <= '0;
            f_way     <= '0;
            f_tag     <= '0;
            f_word    <= '0;
            loc_valid <= 1'b0;
            loc_op    <= '0;
            loc_addr  <= '0;
            loc_wdata <= '0;
            rmt_valid <= 1'b0;
            rmt_op    <= '0;
            rmt_addr  <= '0;
            rmt_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            loc_valid <= 1'b0;
            rmt_valid <= 1'b0;
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (pend) begin
                        st     <= ST_FLUSH;
                        fl_idx <= '0;
                        pend   <= 1'b0;
                    end else if (acc) begin
                        if (!d_remote) begin
                            loc_valid <= 1'b1;
                            loc_op    <= req_op;
                            loc_addr  <= req_addr;
                            loc_wdata <= req_wdata;
                            st        <= ST_WLOC;
                        end else if (op == OP_RD && hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_line[d_word*DATA_W +: DATA_W];
                        end else begin
                            rmt_valid <= 1'b1;
                            rmt_op    <= req_op;
                            rmt_addr  <= (op == OP_RD) ? {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)}
                                                       : req_addr;
                            rmt_wdata <= req_wdata;
                            fill_pend <= (op == OP_RD);
                            f_set     <= d_set;
                            f_way     <= vic_way;
                            f_tag     <= d_tag;
                            f_word    <= d_word;
                            st        <= ST_WRMT;
                        end
                    end
                end
                ST_FLUSH: begin
                    fl_idx <= fl_idx + 1'b1;
                    if (fl_idx == SB'(SETS - 1)) st <= ST_IDLE;
                end
                ST_WLOC: begin
                    if (loc_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= loc_rsp_rdata;
                        st        <= ST_IDLE;
                    end
                end
                ST_WRMT: begin
                    if (rmt_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= fill_pend ? rmt_rsp_line[f_word*DATA_W +: DATA_W]
                                               : rmt_rsp_line[DATA_W-1:0];
                        fill_pend <= 1'b0;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (new_inv) begin
                pend    <= 1'b1;
                last_ep <= inv_epoch;
            end
        end
    end

    // R1: the local port only ever carries local-partition addresses
    p_loc_is_local_r1: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> loc_addr[OFF_W +: PB] == PB'(PART_ID));
    // R1: the remote port only ever carries remote-partition addresses
    p_rmt_is_remote_r1: assert property (@(posedge clk) disable iff (rst)
        rmt_valid |-> rmt_addr[OFF_W +: PB] != PB'(PART_ID));
    // R1: one downstream path per request
    p_one_path_r1: assert property (@(posedge clk) disable iff (rst)
        !(loc_valid && rmt_valid));
    // R3: a response produced straight from idle causes no port traffic
    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(st == ST_IDLE)) |-> (!rmt_valid && !loc_valid));
    // R8: a repeated epoch never starts a clear
    p_dup_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !pend && inv_valid && inv_epoch == last_ep) |=> st != ST_FLUSH);
    // R7: a running clear keeps going until the last set
    p_flush_runs_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLUSH && fl_idx != SB'(SETS - 1)) |=> st == ST_FLUSH);
endmodule

// File: tb/gpm_remote_cache_bench.sv
module gpm_remote_cache_bench;
    localparam int SETS   = 8;
    localparam int LINE_W = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        loc_valid;
    logic [1:0]  loc_op;
    logic [31:0] loc_addr, loc_wdata;
    logic        loc_rsp_valid = 1'b0;
    logic [31:0] loc_rsp_rdata = '0;
    logic        rmt_valid;
    logic [1:0]  rmt_op;
    logic [31:0] rmt_addr, rmt_wdata;
    logic        rmt_rsp_valid = 1'b0;
    logic [LINE_W-1:0] rmt_rsp_line = '0;
    logic        inv_valid = 1'b0;
    logic [3:0]  inv_epoch = '0;

    gpm_remote_cache u_gpm_remote_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rsp_valid(loc_rsp_valid), .loc_rsp_rdata(loc_rsp_rdata),
        .rmt_valid(rmt_valid), .rmt_op(rmt_op), .rmt_addr(rmt_addr), .rmt_wdata(rmt_wdata),
        .rmt_rsp_valid(rmt_rsp_valid), .rmt_rsp_line(rmt_rsp_line),
        .inv_valid(inv_valid), .inv_epoch(inv_epoch)
    );

    int compared = 0, mismatched = 0;
    int rmt_cnt = 0, loc_cnt = 0;
    logic [31:0] last_rmt_addr, last_loc_addr, last_loc_wdata;
    logic [1:0]  last_loc_op;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // memory model shared by both port responders
    logic [31:0] mem [logic [31:0]];
    function automatic logic [31:0] rdw(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (mem.exists(w)) return mem[w];
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] ra(input int tag, input int set, input int part, input int word);
        return (32'(tag) << 12) | (32'(set) << 9) | (32'(part) << 7) | (32'(word) << 2);
    endfunction

    // remote responder
    initial begin
        logic [1:0]  op;
        logic [31:0] a, d, old;
        forever begin
            @(negedge clk);
            if (rmt_valid) begin
                op = rmt_op; a = rmt_addr; d = rmt_wdata;
                rmt_cnt++; last_rmt_addr = a;
                repeat (2) @(negedge clk);
                rmt_rsp_line = '0;
                if (op == 2'd0) begin
                    for (int i = 0; i < 32; i++) rmt_rsp_line[i*32 +: 32] = rdw(a + 32'(4*i));
                end else if (op == 2'd1) begin
                    mem[{a[31:2], 2'b00}] = d;
                end else begin
                    old = rdw(a);
                    mem[{a[31:2], 2'b00}] = old + d;
                    rmt_rsp_line[31:0] = old;
                end
                rmt_rsp_valid = 1'b1;
                @(negedge clk);
                rmt_rsp_valid = 1'b0;
            end
        end
    end

    // local responder
    initial begin
        logic [1:0]  op;
        logic [31:0] a, d, old;
        forever begin
            @(negedge clk);
            if (loc_valid) begin
                op = loc_op; a = loc_addr; d = loc_wdata;
                loc_cnt++; last_loc_addr = a; last_loc_op = op; last_loc_wdata = d;
                repeat (1) @(negedge clk);
                loc_rsp_rdata = '0;
                if (op == 2'd0) loc_rsp_rdata = rdw(a);
                else if (op == 2'd1) mem[{a[31:2], 2'b00}] = d;
                else begin
                    old = rdw(a);
                    mem[{a[31:2], 2'b00}] = old + d;
                    loc_rsp_rdata = old;
                end
                loc_rsp_valid = 1'b1;
                @(negedge clk);
                loc_rsp_valid = 1'b0;
            end
        end
    end

    // scoreboard
    typedef struct { logic [31:0] data; string tag; } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "unexpected response", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_rdata === e.data, e.tag, rsp_rdata, e.data);
            end
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd, input string tag);
        exp_t e;
        e.tag  = tag;
        e.data = (op == 2'd1) ? 32'h0 : rdw(a);
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic send_inv(input logic [3:0] ep, input int copies, output int low);
        @(negedge clk);
        for (int i = 0; i < copies; i++) begin
            inv_valid = 1'b1; inv_epoch = ep;
            @(negedge clk);
        end
        inv_valid = 1'b0;
        low = 0;
        while (!req_ready) begin low++; @(negedge clk); end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int r0, l0, low;
        logic [31:0] a, b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(req_ready === 1'b1, "R10 req_ready", 32'(req_ready), 32'h1);
        chk(rsp_valid === 1'b0 && loc_valid === 1'b0 && rmt_valid === 1'b0,
            "R10 outputs idle", {29'h0, rsp_valid, loc_valid, rmt_valid}, 32'h0);

        // R1: local read bypasses, twice
        a = ra(1, 0, 0, 3); r0 = rmt_cnt; l0 = loc_cnt;
        do_req(2'd0, a, 32'h0, "R1 local read data");
        do_req(2'd0, a, 32'h0, "R1 local read again");
        chk(loc_cnt == l0 + 2, "R1 local count", 32'(loc_cnt - l0), 32'd2);
        chk(rmt_cnt == r0, "R1 no remote", 32'(rmt_cnt - r0), 32'd0);
        chk(last_loc_addr === a, "R1 local addr unchanged", last_loc_addr, a);
        do_req(2'd1, ra(1, 0, 0, 4), 32'hCAFE_0001, "R1 local write ack");
        chk(last_loc_op === 2'd1 && last_loc_wdata === 32'hCAFE_0001, "R1 local wdata",
            last_loc_wdata, 32'hCAFE_0001);

        // R2: remote read miss
        a = ra(0, 1, 1, 5); r0 = rmt_cnt;
        do_req(2'd0, a, 32'h0, "R2 miss data");
        chk(rmt_cnt == r0 + 1, "R2 one fetch", 32'(rmt_cnt - r0), 32'd1);
        chk(last_rmt_addr === (a & ~32'h7F), "R2 aligned addr", last_rmt_addr, a & ~32'h7F);
        // R3: hit on same line
        b = ra(0, 1, 1, 9); r0 = rmt_cnt; l0 = loc_cnt;
        do_req(2'd0, b, 32'h0, "R3 hit data");
        chk(rmt_cnt == r0 && loc_cnt == l0, "R3 no traffic", 32'(rmt_cnt - r0), 32'd0);

        // R4: write hit then read back
        r0 = rmt_cnt;
        do_req(2'd1, b, 32'hDEAD_BEEF, "R4 write ack");
        chk(rmt_cnt == r0 + 1, "R4 write forwarded", 32'(rmt_cnt - r0), 32'd1);
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R4 readback");
        chk(rmt_cnt == r0, "R4 readback hit", 32'(rmt_cnt - r0), 32'd0);

        // R5: write miss does not allocate
        a = ra(2, 2, 2, 0); r0 = rmt_cnt;
        do_req(2'd1, a, 32'h1234_5678, "R5 write ack");
        do_req(2'd0, a, 32'h0, "R5 read after write miss");
        chk(rmt_cnt == r0 + 2, "R5 read misses", 32'(rmt_cnt - r0), 32'd2);

        // R6: remote atomic drops line, local atomic goes local
        a = ra(0, 1, 1, 5); r0 = rmt_cnt;
        do_req(2'd2, a, 32'h1, "R6 atomic old value");
        do_req(2'd0, a, 32'h0, "R6 read after atomic");
        chk(rmt_cnt == r0 + 2, "R6 line dropped", 32'(rmt_cnt - r0), 32'd2);
        l0 = loc_cnt;
        do_req(2'd2, ra(3, 0, 0, 1), 32'h5, "R6 local atomic");
        chk(loc_cnt == l0 + 1, "R6 local atomic path", 32'(loc_cnt - l0), 32'd1);

        // R8: epoch 0 after reset is a duplicate
        send_inv(4'd0, 1, low);
        chk(low == 0, "R8 no stall on epoch 0", 32'(low), 32'd0);
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R8 line survives");
        chk(rmt_cnt == r0, "R8 still hit", 32'(rmt_cnt - r0), 32'd0);

        // R7: new epoch clears
        send_inv(4'd1, 1, low);
        chk(low >= SETS, "R7 stall length", 32'(low), 32'(SETS));
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R7 data after clear");
        chk(rmt_cnt == r0 + 1, "R7 misses after clear", 32'(rmt_cnt - r0), 32'd1);

        // R8: copies of epoch 1 are ignored
        send_inv(4'd1, 3, low);
        chk(low == 0, "R8 dup no stall", 32'(low), 32'd0);
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R8 dup keeps line");
        chk(rmt_cnt == r0, "R8 dup hit", 32'(rmt_cnt - r0), 32'd0);

        // R7/R8: burst of epoch 2 copies, one clear only
        send_inv(4'd2, 3, low);
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R7 burst clear data");
        chk(rmt_cnt == r0 + 1, "R7 burst cleared", 32'(rmt_cnt - r0), 32'd1);
        send_inv(4'd2, 1, low);
        r0 = rmt_cnt;
        do_req(2'd0, b, 32'h0, "R8 late copy data");
        chk(rmt_cnt == r0, "R8 late copy ignored", 32'(rmt_cnt - r0), 32'd0);

        // R9: replacement in set 5, partition 3
        r0 = rmt_cnt;
        for (int t = 10; t < 14; t++) do_req(2'd0, ra(t, 5, 3, 0), 32'h0, "R9 fill");
        do_req(2'd0, ra(10, 5, 3, 1), 32'h0, "R9 hit A");
        do_req(2'd0, ra(11, 5, 3, 1), 32'h0, "R9 hit B");
        chk(rmt_cnt == r0 + 4, "R9 four fills two hits", 32'(rmt_cnt - r0), 32'd4);
        do_req(2'd0, ra(14, 5, 3, 0), 32'h0, "R9 fill E");
        r0 = rmt_cnt;
        do_req(2'd0, ra(10, 5, 3, 2), 32'h0, "R9 A kept");
        do_req(2'd0, ra(11, 5, 3, 2), 32'h0, "R9 B kept");
        do_req(2'd0, ra(13, 5, 3, 2), 32'h0, "R9 D kept");
        chk(rmt_cnt == r0, "R9 A B D hit", 32'(rmt_cnt - r0), 32'd0);
        do_req(2'd0, ra(12, 5, 3, 2), 32'h0, "R9 C data");
        chk(rmt_cnt == r0 + 1, "R9 C evicted", 32'(rmt_cnt - r0), 32'd1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule